// File: doc/BRIEF.md
# SPI Controller Register Block

This block is the software-visible register file of a serial peripheral controller. A 16-bit peripheral bus reaches seven registers through a single-cycle strobe: control, slave-select flags, status, transmit data, receive data, baud divisor and a receive shadow. The shift engine, the baud clock and DMA lie outside it. What the block does model is how the status flags move when software touches the data buffers. A transmit-buffer write can start a transfer, and so can a receive-buffer read. Which of the two counts as a start depends on the enable bit and on the transfer-start mode field in the control register.

Each accepted strobe is either a well-formed access or an error. An access is well formed when it is two bytes wide and aims at one of the seven word-aligned offsets. Anything else is answered with an error pulse and leaves every register untouched. Read data and the error pulse both come back one cycle after the strobe. The status word is also driven continuously to an output port so that the neighbouring engine can watch it.

Top module: `spi_regblk`

## Requirements
- R1: After reset the registers read back as follows: control 0x0400, flags 0xFF00, status 0x0001, and zero for transmit, receive, baud and shadow.
- R2: The register at byte offset 4*k is, for k = 0..6 in order: control, flags, status, transmit, receive, baud, shadow. A write to any register except status stores the full 16-bit value, and that value reads back unchanged.
- R3: bus_rdata carries the addressed register in the cycle after an accepted read and is 0 in every other cycle. bus_err is 0 after a well-formed access.
- R4: An access whose bus_size is not 2 raises bus_err in the next cycle. It changes no register and no status bit, and its bus_rdata is 0.
- R5: An access to an offset that is not a multiple of 4, or that is 28 or above, raises bus_err in the next cycle and changes no register.
- R6: A status write clears every bit written as 1, except bits 0 (SPIF), 3 (TXS) and 5 (RXS). Those three bits keep their values.
- R7: When control bit 14 (enable) is 1 and control bits [1:0] are 2'b01 (transmit-started), a transmit write sets status bit 5 and clears status bit 3.
- R8: When enable is 1 and the mode field is 2'b00 (receive-started), a receive read clears status bits 5 and 3.
- R9: A transmit write or receive read leaves status unchanged when enable is 0 or when the mode field selects the other trigger.
- R10: stat_out always equals the status register value.
- R11: Reads of the control, flags, status, transmit, baud and shadow registers change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Error pulse, the cycle after a bad access |
| stat_out | output | 16 | Current status word |

## Verification
The assertions assume that at most one access is presented per cycle. They also assume that bus_wr, bus_addr, bus_size and bus_wdata are settled whenever bus_sel is high, so that a status write and a data-buffer trigger never fall on the same edge. The stimulus meets this by driving a single one-cycle strobe from a task on the falling edge, and it drops bus_sel before it presents the next access.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int NREG   = 7;
  localparam int DATA_W = 16;
  localparam int SIZE_W = 3;

  typedef enum logic [2:0] {
    RG_CTL = 3'd0, RG_FLG = 3'd1, RG_STAT = 3'd2, RG_TX = 3'd3,
    RG_RX  = 3'd4, RG_BAUD = 3'd5, RG_SHD = 3'd6
  } reg_idx_e;

  localparam int EN_BIT   = 14;
  localparam int SPIF_BIT = 0;
  localparam int TXS_BIT  = 3;
  localparam int RXS_BIT  = 5;
  localparam logic [1:0] MODE_RX_START = 2'b00;
  localparam logic [1:0] MODE_TX_START = 2'b01;
  localparam logic [DATA_W-1:0] STAT_KEEP =
    DATA_W'((1 << SPIF_BIT) | (1 << TXS_BIT) | (1 << RXS_BIT));

  function automatic logic [DATA_W-1:0] reset_value(input int unsigned i);
    case (i)
      0:       return 16'h0400;
      1:       return 16'hFF00;
      2:       return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] status_after_write(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] wd);
    return cur & ~(wd & ~STAT_KEEP);
  endfunction

  function automatic logic mode_is(input logic [DATA_W-1:0] ctl,
                                   input logic [1:0] mode);
    return ctl[EN_BIT] && (ctl[1:0] == mode);
  endfunction
endpackage

// File: rtl/spi_addr_dec.sv
module spi_addr_dec
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                bus_sel,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [SIZE_W-1:0]   bus_size,
  output logic                good_acc,
  output logic                bad_acc,
  output logic [2:0]          idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              mapped;

  assign word     = bus_addr[ADDR_W-1:2];
  assign idx      = 3'(word);
  assign mapped   = (bus_addr[1:0] == 2'b00) && (word < WORD_W'(NREG));
  assign good_acc = bus_sel && mapped && (bus_size == SIZE_W'(2));
  assign bad_acc  = bus_sel && !good_acc;
endmodule

// File: rtl/spi_stat_unit.sv
module spi_stat_unit
  import spi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_trig,
  input  logic              rx_trig,
  output logic [DATA_W-1:0] stat_q
);
  logic [DATA_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = status_after_write(stat_q, wdata);
    if (tx_trig) begin
      stat_d[RXS_BIT] = 1'b1;
      stat_d[TXS_BIT] = 1'b0;
    end
    if (rx_trig) begin
      stat_d[RXS_BIT] = 1'b0;
      stat_d[TXS_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= reset_value(RG_STAT);
    else        stat_q <= stat_d;

  // R6
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & STAT_KEEP) == ($past(stat_q) & STAT_KEEP)));
  // R7
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig |=> (stat_q[RXS_BIT] && !stat_q[TXS_BIT]));
  // R8
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |=> (!stat_q[RXS_BIT] && !stat_q[TXS_BIT]));
endmodule

// File: rtl/spi_regblk.sv
module spi_regblk
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  output logic [15:0]       stat_out
);
  logic              good_acc, bad_acc;
  logic [2:0]        idx;
  logic              wr_hit, rd_hit, tx_trig, rx_trig;
  logic [NREG-1:0][DATA_W-1:0] view;
  logic [DATA_W-1:0] stat_q, ctl_q;

  spi_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_size(bus_size),
    .good_acc(good_acc), .bad_acc(bad_acc), .idx(idx)
  );

  assign wr_hit  = good_acc && bus_wr;
  assign rd_hit  = good_acc && !bus_wr;
  assign ctl_q   = view[RG_CTL];
  assign tx_trig = wr_hit && (idx == RG_TX) && mode_is(ctl_q, MODE_TX_START);
  assign rx_trig = rd_hit && (idx == RG_RX) && mode_is(ctl_q, MODE_RX_START);

  spi_stat_unit u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr(wr_hit && (idx == RG_STAT)),
    .wdata(bus_wdata), .tx_trig(tx_trig), .rx_trig(rx_trig), .stat_q(stat_q)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(RG_STAT)) begin : g_stat
      assign view[i] = stat_q;
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                        q <= reset_value(i);
        else if (wr_hit && idx == 3'(i))   q <= bus_wdata;
      assign view[i] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? view[idx] : '0;
      bus_err   <= bad_acc;
    end

  assign stat_out = stat_q;

  // R4
  bad_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> $stable(view));
  // R5
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> (bus_err && bus_rdata == '0));
  // R11
  rd_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && idx != RG_RX) |=> $stable(view));
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> (bus_rdata == '0 && !bus_err));
endmodule

// File: tb/sim_spi_regblk.sv
module sim_spi_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd2;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, stat_out;
  logic        bus_err;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_regblk u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [2:0] sz,
                     input logic [15:0] wd, output logic [15:0] rd, output logic err);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd = bus_rdata; err = bus_err;
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] r; logic e;
    acc(1'b1, a, 3'd2, d, r, e);
  endtask

  task automatic rd16(input logic [4:0] a, output logic [15:0] d);
    logic e;
    acc(1'b0, a, 3'd2, 16'h0, d, e);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    logic [15:0] exp [7] = '{16'h0400, 16'hFF00, 16'h0001, 0, 0, 0, 0};
    for (int k = 0; k < 7; k++) begin
      rd16(5'(4*k), d); chk("R1 reset value", d, exp[k]);
    end
    chk("R10 stat_out after reset", stat_out, 16'h0001);
    @(negedge clk); chk("R3 idle rdata zero", bus_rdata, 16'h0);
  endtask

  task automatic t_map;
    logic [15:0] d;
    wr16(5'd4, 16'hA55A);  wr16(5'd12, 16'h1234); wr16(5'd16, 16'hBEEF);
    wr16(5'd20, 16'h0F0F); wr16(5'd24, 16'hC3C3);
    rd16(5'd4, d);  chk("R2 flags readback", d, 16'hA55A);
    rd16(5'd12, d); chk("R2 tx readback", d, 16'h1234);
    rd16(5'd16, d); chk("R2 rx readback", d, 16'hBEEF);
    rd16(5'd20, d); chk("R2 baud readback", d, 16'h0F0F);
    rd16(5'd24, d); chk("R2 shadow readback", d, 16'hC3C3);
    rd16(5'd8, d);  chk("R11 status unchanged by reads", d, 16'h0001);
  endtask

  task automatic t_errors;
    logic [15:0] d; logic e;
    acc(1'b1, 5'd20, 3'd1, 16'hFFFF, d, e); chk("R4 size1 write err", 16'(e), 16'h1);
    acc(1'b0, 5'd20, 3'd4, 16'h0, d, e);
    chk("R4 size4 read err", 16'(e), 16'h1); chk("R4 bad read data", d, 16'h0);
    rd16(5'd20, d); chk("R4 baud unchanged", d, 16'h0F0F);
    acc(1'b1, 5'd28, 3'd2, 16'h1111, d, e); chk("R5 offset 28 err", 16'(e), 16'h1);
    acc(1'b1, 5'd6, 3'd2, 16'h2222, d, e);  chk("R5 misaligned err", 16'(e), 16'h1);
    rd16(5'd4, d); chk("R5 flags unchanged", d, 16'hA55A);
    acc(1'b0, 5'd0, 3'd2, 16'h0, d, e); chk("R3 good access no err", 16'(e), 16'h0);
  endtask

  task automatic t_triggers;
    logic [15:0] d; logic e;
    wr16(5'd8, 16'hFFFF); rd16(5'd8, d); chk("R6 kept bits after w1c", d, 16'h0001);
    wr16(5'd0, 16'h0001); wr16(5'd12, 16'h5555);
    chk("R9 disabled tx write", stat_out, 16'h0001);
    wr16(5'd0, 16'h4001); wr16(5'd12, 16'h6666);
    rd16(5'd8, d); chk("R7 tx-start sets RXS", d, 16'h0021);
    chk("R10 stat_out follows", stat_out, 16'h0021);
    wr16(5'd8, 16'hFFFF); rd16(5'd8, d); chk("R6 RXS protected", d, 16'h0021);
    rd16(5'd16, d); chk("R9 mode 01 rx read", stat_out, 16'h0021);
    wr16(5'd0, 16'h4002); rd16(5'd16, d); chk("R9 mode 10 rx read", stat_out, 16'h0021);
    wr16(5'd0, 16'h0000); rd16(5'd16, d); chk("R9 disabled rx read", stat_out, 16'h0021);
    wr16(5'd0, 16'h4000); wr16(5'd12, 16'h7777); chk("R9 mode 00 tx write", stat_out, 16'h0021);
    acc(1'b0, 5'd16, 3'd1, 16'h0, d, e); chk("R4 bad-size rx read no clear", stat_out, 16'h0021);
    rd16(5'd16, d); chk("R8 rx read data", d, 16'hBEEF);
    chk("R8 rx-start clears RXS TXS", stat_out, 16'h0001);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_map(); t_errors(); t_triggers();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule